// File: doc/BRIEF.md
# Processor Reset and Lock Sequencer

This block produces an active-low processor reset that doubles as a lock indicator for a clock generator. It runs on the output-rate clock, which keeps toggling while the reset is held. After power-on the reset is held until the clock generator reports lock, and is then stretched by a fixed number of output clock cycles before release. A reset request on a separate active-low pin asserts the reset at once. Once the request is withdrawn, the reset stays asserted for about the same stretch before release.

The output is open drain. The block drives a single enable: when it is 1 the pad is pulled low, and when it is 0 the pad floats and an external pull-up takes it high. The pad is never driven high. The request pin is captured by a flag that is set asynchronously, so a pulse much shorter than a clock period is still seen. The flag is then synchronized into the clock domain. The lock flag is taken as synchronous to the clock.

Top module: `proc_reset_seq`

## Requirements
- R1: After power-on reset with the request pin high, rst_pull_o stays 1 for as long as lock_i is sampled low.
- R2: With the request inactive, rst_pull_o goes to 0 exactly STRETCH_CYCLES (1024) rising edges after the first edge that samples lock_i high.
- R3: If rst_req_ni is low when power-on reset ends, rst_pull_o stays 1 for as long as rst_req_ni stays low, whatever lock_i does.
- R4: A falling edge on rst_req_ni sets rst_pull_o to 1 without waiting for a clock edge, and a low pulse shorter than one clock period is captured.
- R5: When rst_req_ni returns high with lock_i high, rst_pull_o goes to 0 on a rising edge numbered between STRETCH_CYCLES-8 and STRETCH_CYCLES, counting the first edge after the rise as edge 1.
- R6: A new request while the stretch is running restarts the stretch, so release is timed from the latest request.
- R7: lock_i sampled low on any edge sets rst_pull_o to 1 after that edge. When lock returns, the full STRETCH_CYCLES count runs again before release.
- R8: rst_pull_o is 1 (drive pad low) while rst_ni is low. A value of 0 means the pad is released to high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_req_ni | input | 1 | Reset request, active low, asynchronous |
| lock_i | input | 1 | Clock generator lock flag, synchronous to clk_i |
| rst_pull_o | output | 1 | Open-drain enable: 1 pulls the reset pad low, 0 releases it |

## Verification
The bench times every release against a window worked out from the stimulus. This covers the exact count after lock, and both a long-held request and a sub-cycle request pulse. A design that did not compensate for synchronizer latency would release a few cycles late and miss the window. A design that sampled the request only on clock edges would miss the short pulse and never assert. A second request in the middle of the stretch must push the release out; a counter that was not reloaded would release early, and the monitor reports that as an unexpected release. Lock loss during the stretch and after release, and power-up with the request held low past the full count, check that the reset is never released without lock or while the request is held.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_LOCK = 2'd0,
    ST_HOLD      = 2'd1,
    ST_STRETCH   = 2'd2,
    ST_RELEASED  = 2'd3
  } prs_state_e;
endpackage

// File: rtl/prs_req_capture.sv
module prs_req_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic flag_o,
  output logic req_sync_o
);
  logic             flag_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic             ack;

  assign ack = sync_q[SYNC_STAGES-1];

  // async set on request, cleared once the synchronized copy has seen it
  always_ff @(posedge clk_i or negedge rst_ni or negedge req_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (!req_ni)     flag_q <= 1'b1;
    else if (ack)         flag_q <= 1'b0;
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= flag_q;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign flag_o     = flag_q;
  assign req_sync_o = ack;

  assert_flag_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ni |=> flag_q);
endmodule

// File: rtl/prs_stretch_cnt.sv
module prs_stretch_cnt #(
  parameter int STRETCH_CYCLES = 1024,
  localparam int CNT_W = $clog2(STRETCH_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             en_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STRETCH_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= start_i;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cnt_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(start_i));
endmodule

// File: rtl/prs_ctrl.sv
module prs_ctrl
  import prs_pkg::*;
#(
  parameter int STRETCH_CYCLES = 1024,
  parameter int REQ_LEAD = 6,
  localparam int CNT_W = $clog2(STRETCH_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_sync_i,
  input  logic             lock_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [CNT_W-1:0] start_o,
  output logic             en_o,
  output logic             hold_o
);
  prs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    start_o = '0;
    en_o    = 1'b0;
    if (req_sync_i) begin
      state_d = ST_HOLD;
      load_o  = 1'b1;
    end else if (!lock_i) begin
      state_d = ST_WAIT_LOCK;
      load_o  = 1'b1;
    end else begin
      unique case (state_q)
        ST_WAIT_LOCK: begin
          state_d = ST_STRETCH;
          load_o  = 1'b1;
        end
        ST_HOLD: begin
          // skip the cycles already spent in the synchronizer
          state_d = ST_STRETCH;
          load_o  = 1'b1;
          start_o = CNT_W'(REQ_LEAD);
        end
        ST_STRETCH: begin
          if (last_i) state_d = ST_RELEASED;
          else        en_o    = 1'b1;
        end
        default: state_d = ST_RELEASED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT_LOCK;
    else         state_q <= state_d;
  end

  assign hold_o = (state_q != ST_RELEASED);

  assert_req_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_sync_i |=> state_q == ST_HOLD);
  assert_release_needs_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELEASED && $past(state_q) != ST_RELEASED) |-> $past(last_i));
endmodule

// File: rtl/proc_reset_seq.sv
module proc_reset_seq #(
  parameter int STRETCH_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_req_ni,
  input  logic lock_i,
  output logic rst_pull_o
);
  localparam int CNT_W    = $clog2(STRETCH_CYCLES);
  // request-to-stretch latency: capture clear, sync stages, hold, load
  localparam int REQ_LEAD = SYNC_STAGES + 4;

  logic             flag, req_sync, last, load, en, hold;
  logic [CNT_W-1:0] start;

  prs_req_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_ni(rst_req_ni),
    .flag_o(flag), .req_sync_o(req_sync)
  );

  prs_ctrl #(.STRETCH_CYCLES(STRETCH_CYCLES), .REQ_LEAD(REQ_LEAD)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_sync_i(req_sync), .lock_i(lock_i),
    .last_i(last), .load_o(load), .start_o(start), .en_o(en), .hold_o(hold)
  );

  prs_stretch_cnt #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .start_i(start),
    .en_i(en), .last_o(last)
  );

  assign rst_pull_o = hold | flag;

  assert_req_pulls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_ni |-> rst_pull_o);
  assert_lock_loss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> rst_pull_o);
  assert_release_locked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_pull_o) |-> $past(lock_i));
endmodule

// File: tb/tb_proc_reset_seq.sv
module tb_proc_reset_seq;
  localparam int N = 1024;

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_req_ni = 1'b1;
  logic lock_i = 1'b0;
  logic rst_pull_o;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic prev_pull = 1'b1;
  exp_t q[$];

  proc_reset_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_ni(rst_req_ni),
    .lock_i(lock_i), .rst_pull_o(rst_pull_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  // monitor: every release must match the oldest expected window
  always @(negedge clk) begin
    if (prev_pull === 1'b1 && rst_pull_o === 1'b0) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6: unexpected release, actual cycle %0d expected none", cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (cyc < e.lo || cyc > e.hi) begin
          n_bad++;
          $display("FAIL %s: release actual cycle %0d expected %0d..%0d", e.tag, cyc, e.lo, e.hi);
        end
      end
    end
    prev_pull = rst_pull_o;
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    wait_neg(2);
  endtask

  task automatic push(input int lo, input int hi, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.tag = tag;
    q.push_back(e);
  endtask

  // sub-cycle request pulse, then window for the release
  task automatic short_req(input string tag);
    @(negedge clk);
    #1 rst_req_ni = 1'b0;
    #1 chk(rst_pull_o === 1'b1, "R4", int'(rst_pull_o), 1);
    #1 rst_req_ni = 1'b1;
    push(cyc + N - 8, cyc + N, tag);
  endtask

  task automatic lock_rise(input string tag);
    @(negedge clk);
    push(cyc + 1 + N, cyc + 1 + N, tag);
    lock_i = 1'b1;
  endtask

  initial begin
    wait_neg(3);
    chk(rst_pull_o === 1'b1, "R8", int'(rst_pull_o), 1);
    rst_ni = 1'b1;
    wait_neg(40);
    chk(rst_pull_o === 1'b1, "R1", int'(rst_pull_o), 1);

    // R2: exact stretch after lock
    lock_rise("R2");
    wait_neg(N - 10);
    chk(rst_pull_o === 1'b1, "R2", int'(rst_pull_o), 1);
    drain();
    chk(rst_pull_o === 1'b0, "R8", int'(rst_pull_o), 0);

    // R4/R5: short pulse while released
    short_req("R5");
    drain();

    // R5: long held request
    @(negedge clk) rst_req_ni = 1'b0;
    wait_neg(20);
    chk(rst_pull_o === 1'b1, "R5", int'(rst_pull_o), 1);
    #2 rst_req_ni = 1'b1;
    push(cyc + N - 8, cyc + N, "R5");
    drain();

    // R6: second request mid-stretch restarts the count
    @(negedge clk); #1 rst_req_ni = 1'b0; #2 rst_req_ni = 1'b1;
    wait_neg(300);
    chk(rst_pull_o === 1'b1, "R6", int'(rst_pull_o), 1);
    short_req("R6");
    drain();

    // R7: lock loss after release
    @(negedge clk) lock_i = 1'b0;
    @(negedge clk);
    chk(rst_pull_o === 1'b1, "R7", int'(rst_pull_o), 1);
    wait_neg(5);
    lock_rise("R7");
    drain();

    // R7: lock loss mid-stretch reruns the full count
    @(negedge clk) lock_i = 1'b0;
    wait_neg(3);
    lock_i = 1'b1;
    wait_neg(500);
    lock_i = 1'b0;
    wait_neg(2);
    chk(rst_pull_o === 1'b1, "R7", int'(rst_pull_o), 1);
    lock_rise("R7");
    drain();

    // R1: request released while unlocked waits for lock
    @(negedge clk) begin lock_i = 1'b0; rst_req_ni = 1'b0; end
    wait_neg(10);
    rst_req_ni = 1'b1;
    wait_neg(30);
    chk(rst_pull_o === 1'b1, "R1", int'(rst_pull_o), 1);
    lock_rise("R1");
    drain();

    // R3: request held low through power-on reset
    @(negedge clk) begin rst_ni = 1'b0; rst_req_ni = 1'b0; end
    wait_neg(2);
    chk(rst_pull_o === 1'b1, "R8", int'(rst_pull_o), 1);
    rst_ni = 1'b1;
    wait_neg(N + 80);
    chk(rst_pull_o === 1'b1, "R3", int'(rst_pull_o), 1);
    #2 rst_req_ni = 1'b1;
    push(cyc + N - 8, cyc + N, "R5");
    drain();
    chk(rst_pull_o === 1'b0, "R5", int'(rst_pull_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion (R1..)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule